// File: doc/BRIEF.md
# Memory-Ordering Group Dispatcher

This block sits at the dispatch stage of an out-of-order core, in front of the load and store queues. Each cycle it takes at most one dispatch request. The request is flagged with three bits: may-load, may-store and side-effect. The block classes the request as a plain load, a plain store, a load barrier, a store barrier or a full barrier. It keeps an occupancy count for each queue, drives a two-bit availability status, and accepts the request only when that status is zero.

Every accepted memory operation receives a nonzero dependency group identifier. A plain load may join the group already open for loads. Every other memory operation opens a new group. For each new group the block drives up to four successor-link commands towards an external dependency tracker, one per slot, and each command names an older group the new one must wait on. Queue entries are released by retire strobes. An execute notification for a group removes that group from the block's view of open groups.

The dependency tracker's counters, address comparison and forwarding are handled elsewhere.

Top module: `lsq_order_dispatch`

## Requirements
- R1: After reset both queues are empty, no group is open, and the first new group receives identifier 1. With no dispatch request the status is 0, the group output is 0 and no link is valid.
- R2: The status is 0 for available, 1 when a request that may load meets a full load queue, and 2 when a request that may store meets a full store queue. The load check takes priority for a full barrier. A request that neither loads nor stores gets status 0 and group 0. A rejected request gets group 0.
- R3: A queue parameterised with size 0 never reports full. Otherwise the queue is full exactly when its count equals its size.
- R4: An accepted request that may load takes one load-queue entry, and one that may store takes one store-queue entry, so a full barrier takes one of each. ret_load and ret_store each free one entry. A take and a free in the same cycle leave the count unchanged.
- R5: New groups receive consecutive identifiers. After the largest value the sequence wraps to 1, and 0 is never assigned.
- R6: A plain load (may-load only) joins the open load group when one exists and no store, barrier or load-and-store operation has been accepted since that group was opened. A joining load gets that group's identifier and drives no links.
- R7: A new group that may store receives a data link from the open store group (slot 0), a data link from the open store barrier (slot 1), an order link from the open load group (slot 2), and a data link from the open load barrier (slot 3).
- R8: A new group that may load receives a data link from the open load barrier (slot 3). It also receives a data link from the open store group (slot 0) only when NO_ALIAS is 0, which is the default.
- R9: A load barrier additionally receives an order link from the open load group (slot 2).
- R10: A full barrier becomes both the open load barrier and the open store barrier. When slot 1 and slot 3 would name the same group, slot 3 is suppressed.
- R11: An exe_valid strobe clears every open-group record equal to exe_group. Later requests then receive no link from that group.
- R12: link_dst is not a separate port. The destination of every link is disp_gid in the same cycle, and link_src packs slot k in bits [k*GID_W +: GID_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request present |
| disp_may_load | input | 1 | Request reads memory |
| disp_may_store | input | 1 | Request writes memory |
| disp_side_fx | input | 1 | Request has side effects (barrier) |
| ret_load | input | 1 | Free one load-queue entry |
| ret_store | input | 1 | Free one store-queue entry |
| exe_valid | input | 1 | A group has finished executing |
| exe_group | input | GID_W | Identifier of the executed group |
| disp_status | output | 2 | 0 available, 1 load queue full, 2 store queue full |
| disp_gid | output | GID_W | Group assigned to the accepted request, else 0 |
| link_valid | output | 4 | Per-slot successor link strobe |
| link_src | output | 4*GID_W | Per-slot older group identifier |

## Verification
The assertions rely on a few conditions at the inputs. A retire strobe never arrives for an empty queue. An execute notification never shares a cycle with a dispatch. A group identifier is not reused while an older group with the same value is still recorded as open. The stimulus meets the first two conditions by gating every retire and every execute strobe on the bench's own queue counts and open-group records. Identifier reuse is harmless in this bench, because its reference model applies the same equality rules as the design, so a stale record is predicted rather than avoided.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_LQ_FULL = 2'd1,
    ST_SQ_FULL = 2'd2
  } lsq_status_e;

  // decoded request class, already gated by the request valid
  typedef struct packed {
    logic is_mem;
    logic ld_cls;
    logic st_cls;
    logic plain_ld;
    logic plain_st;
    logic ld_bar;
    logic st_bar;
  } op_class_t;

  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SLOT_SG   = 0;  // open store group, data link
  localparam int unsigned SLOT_SBG  = 1;  // open store barrier, data link
  localparam int unsigned SLOT_LG   = 2;  // open load group, order link
  localparam int unsigned SLOT_LBG  = 3;  // open load barrier, data link

endpackage

// File: rtl/lsq_classify.sv
`timescale 1ns/1ps
module lsq_classify
  import lsq_pkg::*;
(
  input  logic      req_valid,
  input  logic      may_load,
  input  logic      may_store,
  input  logic      side_fx,
  output op_class_t cls
);

  always_comb begin
    cls          = '0;
    cls.is_mem   = req_valid & (may_load | may_store);
    cls.ld_cls   = req_valid & may_load;
    cls.st_cls   = req_valid & may_store;
    cls.plain_ld = req_valid & may_load & ~may_store & ~side_fx;
    cls.plain_st = req_valid & may_store & ~side_fx;
    cls.ld_bar   = req_valid & may_load & side_fx;
    cls.st_bar   = req_valid & may_store & side_fx;
  end

endmodule

// File: rtl/lsq_occupancy.sv
`timescale 1ns/1ps
module lsq_occupancy #(
  parameter int unsigned SIZE  = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic full
);

  logic [CNT_W-1:0] used_q;
  logic [CNT_W-1:0] used_d;
  logic             used_en;

  always_comb begin
    used_en = take ^ give;
    used_d  = used_q;
    if (take && !give) used_d = used_q + CNT_W'(1);
    if (give && !take) used_d = used_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       used_q <= '0;
    else if (used_en) used_q <= used_d;
  end

  generate
    if (SIZE == 0) begin : g_unbounded
      assign full = 1'b0;
    end else begin : g_bounded
      assign full = (used_q == CNT_W'(SIZE));

      // R3: a bounded queue never holds more than its size
      a_r3_within_size: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= CNT_W'(SIZE));
    end
  endgenerate

  // R4: an entry is never freed from an empty queue unless one is taken alongside
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take) |-> (used_q != '0));

  // R4: the count moves by the net of take and free
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && give) |=> $stable(used_q));

endmodule

// File: rtl/lsq_group_track.sv
`timescale 1ns/1ps
module lsq_group_track
  import lsq_pkg::*;
#(
  parameter int unsigned GID_W    = 6,
  parameter bit          NO_ALIAS = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            accept,
  input  op_class_t                       cls,
  input  logic                            exe_valid,
  input  logic [GID_W-1:0]                exe_group,
  output logic [GID_W-1:0]                gid,
  output logic [NUM_SLOTS-1:0]            lnk_valid,
  output logic [NUM_SLOTS-1:0][GID_W-1:0] lnk_src
);

  localparam logic [GID_W-1:0] ID_MAX   = {GID_W{1'b1}};
  localparam logic [GID_W-1:0] ID_FIRST = GID_W'(1);

  logic [GID_W-1:0] lg_q, lbg_q, sg_q, sbg_q, nid_q;
  logic [GID_W-1:0] lg_d, lbg_d, sg_d, sbg_d, nid_d;
  logic             join_ok_q, join_ok_d;
  logic             joins, new_grp, upd_en;

  always_comb begin
    joins   = accept & cls.plain_ld & (lg_q != '0) & join_ok_q;
    new_grp = accept & ~joins;

    if (!accept)   gid = '0;
    else if (joins) gid = lg_q;
    else            gid = nid_q;

    lnk_src[SLOT_SG]  = sg_q;
    lnk_src[SLOT_SBG] = sbg_q;
    lnk_src[SLOT_LG]  = lg_q;
    lnk_src[SLOT_LBG] = lbg_q;

    lnk_valid[SLOT_SG]  = new_grp & (sg_q != '0) &
                          (cls.st_cls | (cls.ld_cls & ~NO_ALIAS));
    lnk_valid[SLOT_SBG] = new_grp & (sbg_q != '0) & cls.st_cls;
    lnk_valid[SLOT_LG]  = new_grp & (lg_q != '0) & (cls.st_cls | cls.ld_bar);
    lnk_valid[SLOT_LBG] = new_grp & (lbg_q != '0) &
                          ~(lnk_valid[SLOT_SBG] & (sbg_q == lbg_q));
  end

  always_comb begin
    lg_d      = lg_q;
    lbg_d     = lbg_q;
    sg_d      = sg_q;
    sbg_d     = sbg_q;
    nid_d     = nid_q;
    join_ok_d = join_ok_q;

    if (exe_valid) begin
      if (exe_group == lg_q)  lg_d  = '0;
      if (exe_group == lbg_q) lbg_d = '0;
      if (exe_group == sg_q)  sg_d  = '0;
      if (exe_group == sbg_q) sbg_d = '0;
    end

    if (accept && !cls.plain_ld) join_ok_d = 1'b0;

    if (new_grp) begin
      nid_d = (nid_q == ID_MAX) ? ID_FIRST : nid_q + GID_W'(1);
      if (cls.plain_ld) begin
        lg_d      = nid_q;
        join_ok_d = 1'b1;
      end
      if (cls.plain_st) sg_d  = nid_q;
      if (cls.ld_bar)   lbg_d = nid_q;
      if (cls.st_bar)   sbg_d = nid_q;
    end
  end

  assign upd_en = accept | exe_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg_q      <= '0;
      lbg_q     <= '0;
      sg_q      <= '0;
      sbg_q     <= '0;
      nid_q     <= ID_FIRST;
      join_ok_q <= 1'b0;
    end else if (upd_en) begin
      lg_q      <= lg_d;
      lbg_q     <= lbg_d;
      sg_q      <= sg_d;
      sbg_q     <= sbg_d;
      nid_q     <= nid_d;
      join_ok_q <= join_ok_d;
    end
  end

  // R5: the identifier allocator never holds zero
  a_r5_id_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    nid_q != '0);

  // R5: every new group moves the allocator on
  a_r5_id_advances: assert property (@(posedge clk) disable iff (!rst_n)
    new_grp |=> (nid_q != $past(nid_q)));

  // R6: a joining load drives no link
  a_r6_join_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    joins |-> (lnk_valid == '0));

  // R11: an executed open load group is forgotten
  a_r11_exe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && !accept && exe_group == lg_q) |=> (lg_q == '0));

endmodule

// File: rtl/lsq_order_dispatch.sv
`timescale 1ns/1ps
module lsq_order_dispatch
  import lsq_pkg::*;
#(
  parameter int unsigned LQ_SIZE  = 16,
  parameter int unsigned SQ_SIZE  = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned GID_W    = 6,
  parameter bit          NO_ALIAS = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         disp_valid,
  input  logic                         disp_may_load,
  input  logic                         disp_may_store,
  input  logic                         disp_side_fx,
  input  logic                         ret_load,
  input  logic                         ret_store,
  input  logic                         exe_valid,
  input  logic [GID_W-1:0]             exe_group,
  output logic [1:0]                   disp_status,
  output logic [GID_W-1:0]             disp_gid,
  output logic [NUM_SLOTS-1:0]         link_valid,
  output logic [NUM_SLOTS*GID_W-1:0]   link_src
);

  op_class_t                       cls;
  lsq_status_e                     status;
  logic                            lq_full, sq_full, accept;
  logic [NUM_SLOTS-1:0][GID_W-1:0] src_arr;

  lsq_classify u_cls (
    .req_valid (disp_valid),
    .may_load  (disp_may_load),
    .may_store (disp_may_store),
    .side_fx   (disp_side_fx),
    .cls       (cls)
  );

  always_comb begin
    status = ST_OK;
    if (cls.ld_cls && lq_full)      status = ST_LQ_FULL;
    else if (cls.st_cls && sq_full) status = ST_SQ_FULL;
    accept = cls.is_mem & (status == ST_OK);
  end

  assign disp_status = status;

  lsq_occupancy #(.SIZE(LQ_SIZE), .CNT_W(CNT_W)) u_lq (
    .clk  (clk),
    .rst_n(rst_n),
    .take (accept & cls.ld_cls),
    .give (ret_load),
    .full (lq_full)
  );

  lsq_occupancy #(.SIZE(SQ_SIZE), .CNT_W(CNT_W)) u_sq (
    .clk  (clk),
    .rst_n(rst_n),
    .take (accept & cls.st_cls),
    .give (ret_store),
    .full (sq_full)
  );

  lsq_group_track #(.GID_W(GID_W), .NO_ALIAS(NO_ALIAS)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .cls      (cls),
    .exe_valid(exe_valid),
    .exe_group(exe_group),
    .gid      (disp_gid),
    .lnk_valid(link_valid),
    .lnk_src  (src_arr)
  );

  generate
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pack
      assign link_src[k*GID_W +: GID_W] = src_arr[k];
    end
  endgenerate

  // R2: a request touching no memory is always available
  a_r2_nonmem_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_may_load && !disp_may_store) |-> (disp_status == 2'd0));

  // R2: a refused request carries no group
  a_r2_refused_nogroup: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_status != 2'd0) |-> (disp_gid == '0 && link_valid == '0));

  // R12: links only accompany a freshly assigned group
  a_r12_link_has_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid != '0) |-> (disp_gid != '0));

endmodule

// File: tb/tb_lsq_order_dispatch.sv
`timescale 1ns/1ps
module tb_lsq_order_dispatch;

  localparam int GW = 4;
  localparam int LQ = 2;
  localparam int SQ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dv = 0, dl = 0, ds = 0, dx = 0, rl = 0, rs = 0, xv = 0;
  logic [GW-1:0] xg = '0;

  logic [1:0]    st_a, st_b, st_u;
  logic [GW-1:0] g_a, g_b, g_u;
  logic [3:0]    lv_a, lv_b, lv_u;
  logic [4*GW-1:0] ls_a, ls_b, ls_u;

  always #10 clk = ~clk;

  lsq_order_dispatch #(.LQ_SIZE(LQ), .SQ_SIZE(SQ), .CNT_W(4), .GID_W(GW), .NO_ALIAS(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_may_load(dl), .disp_may_store(ds),
    .disp_side_fx(dx), .ret_load(rl), .ret_store(rs), .exe_valid(xv), .exe_group(xg),
    .disp_status(st_a), .disp_gid(g_a), .link_valid(lv_a), .link_src(ls_a));

  lsq_order_dispatch #(.LQ_SIZE(LQ), .SQ_SIZE(SQ), .CNT_W(4), .GID_W(GW), .NO_ALIAS(1'b1)) dut_na (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_may_load(dl), .disp_may_store(ds),
    .disp_side_fx(dx), .ret_load(rl), .ret_store(rs), .exe_valid(xv), .exe_group(xg),
    .disp_status(st_b), .disp_gid(g_b), .link_valid(lv_b), .link_src(ls_b));

  lsq_order_dispatch #(.LQ_SIZE(0), .SQ_SIZE(0), .CNT_W(12), .GID_W(GW), .NO_ALIAS(1'b0)) dut_ub (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_may_load(dl), .disp_may_store(ds),
    .disp_side_fx(dx), .ret_load(rl), .ret_store(rs), .exe_valid(xv), .exe_group(xg),
    .disp_status(st_u), .disp_gid(g_u), .link_valid(lv_u), .link_src(ls_u));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_lq, m_sq;
  logic [GW-1:0] m_lg, m_lbg, m_sg, m_sbg, m_nid;
  bit m_join;

  // last sampled values
  logic [1:0] s_st;
  logic [GW-1:0] s_gid;
  logic [3:0] s_lv_a, s_lv_b;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lq = 0; m_sq = 0;
    m_lg = '0; m_lbg = '0; m_sg = '0; m_sbg = '0;
    m_nid = GW'(1); m_join = 0;
  endtask

  task automatic step(input bit v, input bit l, input bit s, input bit f,
                      input bit r_l, input bit r_s, input bit x, input logic [GW-1:0] g);
    int e_st;
    bit mem, acc, jn, newg;
    logic [GW-1:0] e_gid;
    logic [3:0] e_lv_a, e_lv_b;
    logic [GW-1:0] srcs [4];
    @(negedge clk);
    dv = v; dl = l; ds = s; dx = f; rl = r_l; rs = r_s; xv = x; xg = g;
    #5;
    mem = v && (l || s);
    e_st = 0;
    if (mem && l && m_lq == LQ) e_st = 1;
    else if (mem && s && m_sq == SQ) e_st = 2;
    acc = mem && (e_st == 0);
    jn = acc && l && !s && !f && (m_lg != 0) && m_join;
    newg = acc && !jn;
    e_gid = !acc ? '0 : (jn ? m_lg : m_nid);
    srcs[0] = m_sg; srcs[1] = m_sbg; srcs[2] = m_lg; srcs[3] = m_lbg;
    e_lv_a[1] = newg && m_sbg != 0 && s;
    e_lv_a[2] = newg && m_lg != 0 && (s || (l && f));
    e_lv_a[3] = newg && m_lbg != 0 && !(e_lv_a[1] && m_sbg == m_lbg);
    e_lv_b = e_lv_a;
    e_lv_a[0] = newg && m_sg != 0 && (s || l);
    e_lv_b[0] = newg && m_sg != 0 && s;

    s_st = st_a; s_gid = g_a; s_lv_a = lv_a; s_lv_b = lv_b;
    chk(st_a == 2'(e_st), "R2 R3 R4 status", st_a, e_st);
    chk(st_b == 2'(e_st), "R2 status no-alias", st_b, e_st);
    chk(st_u == 2'd0, "R3 unbounded status", st_u, 0);
    chk(g_a == e_gid, "R5 R6 gid", g_a, e_gid);
    chk(lv_a == e_lv_a, "R7 R8 R9 R10 R11 links", lv_a, e_lv_a);
    chk(lv_b == e_lv_b, "R8 links no-alias", lv_b, e_lv_b);
    for (int k = 0; k < 4; k++) begin
      if (e_lv_a[k]) chk(ls_a[k*GW +: GW] == srcs[k], "R12 link src", ls_a[k*GW +: GW], srcs[k]);
    end

    // model update
    m_lq = m_lq + ((acc && l) ? 1 : 0) - (r_l ? 1 : 0);
    m_sq = m_sq + ((acc && s) ? 1 : 0) - (r_s ? 1 : 0);
    if (x) begin
      if (g == m_lg)  m_lg  = '0;
      if (g == m_lbg) m_lbg = '0;
      if (g == m_sg)  m_sg  = '0;
      if (g == m_sbg) m_sbg = '0;
    end
    if (acc && !(l && !s && !f)) m_join = 0;
    if (newg) begin
      if (l && !s && !f) begin m_lg = m_nid; m_join = 1; end
      if (s && !f) m_sg  = m_nid;
      if (l && f)  m_lbg = m_nid;
      if (s && f)  m_sbg = m_nid;
      m_nid = (m_nid == {GW{1'b1}}) ? GW'(1) : m_nid + GW'(1);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset
    step(0,0,0,0, 0,0, 0,'0);
    chk(s_st == 0 && s_gid == 0 && s_lv_a == 0, "R1 idle", s_gid, 0);
    // R2: non-memory request
    step(1,0,0,1, 0,0, 0,'0);
    chk(s_st == 0 && s_gid == 0, "R2 nonmem", s_gid, 0);
    step(1,1,0,0, 0,0, 0,'0);
    chk(s_gid == 1, "R1 R5 first gid", s_gid, 1);
    step(1,1,0,0, 0,0, 0,'0);
    chk(s_gid == 1, "R6 join", s_gid, 1);
    step(1,1,0,0, 0,0, 0,'0);
    chk(s_st == 1, "R2 R3 lq full", s_st, 1);
    step(1,1,0,0, 1,0, 0,'0);
    step(1,1,0,0, 1,0, 0,'0);
    chk(s_st == 0, "R4 take with free", s_st, 0);
    step(1,1,0,0, 0,0, 0,'0);
    step(1,1,0,0, 0,0, 0,'0);
    chk(s_st == 1, "R4 count after same-cycle", s_st, 1);
    step(0,0,0,0, 1,0, 0,'0);
    step(0,0,0,0, 1,0, 0,'0);
    step(1,0,1,0, 0,0, 0,'0);
    chk(s_gid == 2 && s_lv_a == 4'b0100, "R7 store order link", s_lv_a, 4);
    step(1,1,0,0, 0,0, 0,'0);
    chk(s_lv_a == 4'b0001 && s_lv_b == 4'b0000, "R8 alias link", s_lv_b, 0);
    step(1,1,1,1, 0,0, 0,'0);
    chk(s_gid == 4 && s_lv_a == 4'b0101, "R9 full barrier links", s_lv_a, 5);
    step(1,0,1,0, 0,0, 0,'0);
    chk(s_st == 2, "R2 sq full", s_st, 2);
    step(0,0,0,0, 1,1, 0,'0);
    step(0,0,0,0, 1,1, 0,'0);
    step(1,0,1,0, 0,0, 0,'0);
    chk(s_gid == 5 && s_lv_a == 4'b0111, "R10 suppressed duplicate", s_lv_a, 7);
    step(0,0,0,0, 0,0, 1,GW'(4));
    step(1,0,1,0, 0,0, 0,'0);
    chk(s_lv_a == 4'b0101, "R11 executed barrier dropped", s_lv_a, 5);
    step(0,0,0,0, 0,1, 0,'0);
    step(0,0,0,0, 0,1, 0,'0);

    // near-exhaustive sweep, every class against every queue state
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit v, l, s, f, a, b, x;
      logic [GW-1:0] g;
      r = $urandom;
      v = (r[1:0] != 2'd0);
      l = r[2]; s = r[3]; f = r[4];
      a = r[5] && (m_lq > 0);
      b = r[6] && (m_sq > 0);
      x = !v && r[7];
      case (r[9:8])
        2'd0: g = m_lg;
        2'd1: g = m_lbg;
        2'd2: g = m_sg;
        default: g = m_sbg;
      endcase
      step(v, l, s, f, a, b, x, g);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule